// File: doc/BRIEF.md
# Completion-Bus Operand Forwarding Selector

This block supplies the two source operands of the instruction that sits in decode, in a pipeline whose functional units have unequal latencies. Each cycle, every unit presents a completion slot made of a valid bit, a register-write bit, a destination register index and a result word. The block finds the single unit that is finishing a register-writing instruction and picks that unit's destination and result with a unit-select mux. It then compares the picked destination against each source index. When a source matches, the block supplies the fresh result in place of the value read from the register file.

Each source is handled on its own. One completing result can therefore feed the first operand, the second operand or both. A completion that does not write a register, such as a store leaving execute, is never a forwarding source, even when it completes alongside a writer. When nothing matches, each operand is the register-file value, unchanged. The selector is purely combinational, so it sits between the register-file read ports and the issue register. The stall decision and the register file are separate blocks.

Top module: `fsel_forward_select`

## Requirements
- R1: `opnd1_fwd` is 1 exactly when some unit has `fu_vld`=1 and `fu_wr`=1, its destination equals `s1_idx`, and `s1_vld`=1. In that case `opnd1` equals that unit's result.
- R2: `opnd2_fwd` is 1 exactly when some unit has `fu_vld`=1 and `fu_wr`=1, its destination equals `s2_idx`, and `s2_vld`=1. In that case `opnd2` equals that unit's result.
- R3: The two sources are judged independently. When both indices equal the completing destination and both sources are valid, both operands carry the same result and both flags are 1.
- R4: When a source's flag is 0, its operand equals its register-file input (`s1_rf` or `s2_rf`) bit for bit.
- R5: The destination and result used for forwarding come from the unit whose slot holds the writing completion. Unit i's slot is bits `[i*REG_AW +: REG_AW]` of `fu_dest` and bits `[i*DATA_W +: DATA_W]` of `fu_result`.
- R6: A slot with `fu_vld`=1 and `fu_wr`=0 (a store) never causes a forward. This holds even when its destination matches and it completes in the same cycle as a writing unit; the writing unit is still forwarded.
- R7: A source with its valid bit at 0 is never forwarded, even when its index matches the completing destination.
- R8: At most one slot has both `fu_vld` and `fu_wr` set in any cycle. Any cycle with two or more such slots is flagged as a protocol error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| fu_vld | input | NUM_FU | Per-unit completion valid |
| fu_wr | input | NUM_FU | Per-unit completion writes a register |
| fu_dest | input | NUM_FU*REG_AW | Per-unit destination register index, packed |
| fu_result | input | NUM_FU*DATA_W | Per-unit result word, packed |
| s1_idx | input | REG_AW | First source register index |
| s1_vld | input | 1 | First source is used by the instruction |
| s1_rf | input | DATA_W | Register-file read value for the first source |
| s2_idx | input | REG_AW | Second source register index |
| s2_vld | input | 1 | Second source is used by the instruction |
| s2_rf | input | DATA_W | Register-file read value for the second source |
| opnd1 | output | DATA_W | Final first operand |
| opnd1_fwd | output | 1 | First operand was taken from the completion bus |
| opnd2 | output | DATA_W | Final second operand |
| opnd2_fwd | output | 1 | Second operand was taken from the completion bus |

## Verification
Two things the selector does can coincide in one cycle. First, a store can leave a unit while a writer leaves another unit with the same destination. Second, a single writer can be matched by both sources at once. The sweep covers both cases. It places a store slot next to every writing unit, with its destination equal to the writer's, and it steps both source indices over every register together with every combination of the two source-valid bits. Every unit carries a distinct result. A wrong unit choice, a store being forwarded, or one source blocking the other therefore shows up as a wrong operand value or a wrong flag, compared against the value worked out arithmetically from the sweep indices.

// File: rtl/fsel_pkg.sv
package fsel_pkg;

   // How the completing unit is picked from the writer-valid vector.
   typedef enum logic [0:0] {
      SEL_ANDOR    = 1'b0,   // trust one-hot, plain AND-OR mux
      SEL_PRIORITY = 1'b1    // isolate the lowest set bit first
   } sel_style_e;

   // Isolate the lowest set bit of a vector.
   function automatic logic [63:0] lowest_bit(input logic [63:0] v);
      return v & (~v + 64'd1);
   endfunction

endpackage

// File: rtl/fsel_unit_mux.sv
module fsel_unit_mux
   import fsel_pkg::*;
#(
   parameter int         NUM_FU = 4,
   parameter int         REG_AW = 5,
   parameter int         DATA_W = 64,
   parameter sel_style_e STYLE  = SEL_ANDOR
) (
   input  logic [NUM_FU-1:0]        fu_vld,
   input  logic [NUM_FU-1:0]        fu_wr,
   input  logic [NUM_FU*REG_AW-1:0] fu_dest,
   input  logic [NUM_FU*DATA_W-1:0] fu_result,
   output logic                     cmp_vld,
   output logic [REG_AW-1:0]        cmp_dest,
   output logic [DATA_W-1:0]        cmp_result
);

   logic [NUM_FU-1:0] writer;
   logic [NUM_FU-1:0] grant;

   // Only register-writing completions are candidates; stores drop out here.
   assign writer  = fu_vld & fu_wr;
   assign cmp_vld = |writer;

   generate
      if (STYLE == SEL_PRIORITY) begin : g_prio
         logic [63:0] iso;
         assign iso   = lowest_bit(64'(writer));
         assign grant = iso[NUM_FU-1:0];
      end else begin : g_andor
         assign grant = writer;
      end
   endgenerate

   always_comb begin
      cmp_dest   = '0;
      cmp_result = '0;
      for (int i = 0; i < NUM_FU; i++) begin
         cmp_dest   |= {REG_AW{grant[i]}} & fu_dest[i*REG_AW +: REG_AW];
         cmp_result |= {DATA_W{grant[i]}} & fu_result[i*DATA_W +: DATA_W];
      end
   end

endmodule

// File: rtl/fsel_src_port.sv
module fsel_src_port #(
   parameter int REG_AW = 5,
   parameter int DATA_W = 64
) (
   input  logic              cmp_vld,
   input  logic [REG_AW-1:0] cmp_dest,
   input  logic [DATA_W-1:0] cmp_result,
   input  logic [REG_AW-1:0] src_idx,
   input  logic              src_vld,
   input  logic [DATA_W-1:0] rf_val,
   output logic [DATA_W-1:0] opnd,
   output logic              fwd
);

   logic tag_eq;

   assign tag_eq = (cmp_dest == src_idx);
   assign fwd    = cmp_vld & src_vld & tag_eq;
   assign opnd   = fwd ? cmp_result : rf_val;

endmodule

// File: rtl/fsel_forward_select.sv
module fsel_forward_select
   import fsel_pkg::*;
#(
   parameter int         NUM_FU = 4,
   parameter int         REG_AW = 5,
   parameter int         DATA_W = 64,
   parameter sel_style_e STYLE  = SEL_ANDOR
) (
   input  logic [NUM_FU-1:0]        fu_vld,
   input  logic [NUM_FU-1:0]        fu_wr,
   input  logic [NUM_FU*REG_AW-1:0] fu_dest,
   input  logic [NUM_FU*DATA_W-1:0] fu_result,
   input  logic [REG_AW-1:0]        s1_idx,
   input  logic                     s1_vld,
   input  logic [DATA_W-1:0]        s1_rf,
   input  logic [REG_AW-1:0]        s2_idx,
   input  logic                     s2_vld,
   input  logic [DATA_W-1:0]        s2_rf,
   output logic [DATA_W-1:0]        opnd1,
   output logic                     opnd1_fwd,
   output logic [DATA_W-1:0]        opnd2,
   output logic                     opnd2_fwd
);

   localparam int NUM_SRC = 2;

   if (NUM_FU < 1 || NUM_FU > 64) begin : g_bad_fu
      $error("fsel_forward_select: NUM_FU must lie in 1..64");
   end
   if (REG_AW < 1) begin : g_bad_aw
      $error("fsel_forward_select: REG_AW must be at least 1");
   end
   if (DATA_W < 1) begin : g_bad_dw
      $error("fsel_forward_select: DATA_W must be at least 1");
   end

   logic              cmp_vld;
   logic [REG_AW-1:0] cmp_dest;
   logic [DATA_W-1:0] cmp_result;

   logic [REG_AW-1:0] src_idx [NUM_SRC];
   logic              src_vld [NUM_SRC];
   logic [DATA_W-1:0] src_rf  [NUM_SRC];
   logic [DATA_W-1:0] src_op  [NUM_SRC];
   logic              src_fwd [NUM_SRC];

   fsel_unit_mux #(
      .NUM_FU (NUM_FU),
      .REG_AW (REG_AW),
      .DATA_W (DATA_W),
      .STYLE  (STYLE)
   ) i_unit_mux (
      .fu_vld     (fu_vld),
      .fu_wr      (fu_wr),
      .fu_dest    (fu_dest),
      .fu_result  (fu_result),
      .cmp_vld    (cmp_vld),
      .cmp_dest   (cmp_dest),
      .cmp_result (cmp_result)
   );

   assign src_idx[0] = s1_idx;
   assign src_vld[0] = s1_vld;
   assign src_rf[0]  = s1_rf;
   assign src_idx[1] = s2_idx;
   assign src_vld[1] = s2_vld;
   assign src_rf[1]  = s2_rf;

   for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
      fsel_src_port #(
         .REG_AW (REG_AW),
         .DATA_W (DATA_W)
      ) i_src_port (
         .cmp_vld    (cmp_vld),
         .cmp_dest   (cmp_dest),
         .cmp_result (cmp_result),
         .src_idx    (src_idx[s]),
         .src_vld    (src_vld[s]),
         .rf_val     (src_rf[s]),
         .opnd       (src_op[s]),
         .fwd        (src_fwd[s])
      );
   end

   assign opnd1     = src_op[0];
   assign opnd1_fwd = src_fwd[0];
   assign opnd2     = src_op[1];
   assign opnd2_fwd = src_fwd[1];

endmodule

// File: rtl/fsel_chk.sv
module fsel_chk #(
   parameter int NUM_FU = 4,
   parameter int REG_AW = 5,
   parameter int DATA_W = 64
) (
   input logic [NUM_FU-1:0]        fu_vld,
   input logic [NUM_FU-1:0]        fu_wr,
   input logic [NUM_FU*REG_AW-1:0] fu_dest,
   input logic [NUM_FU*DATA_W-1:0] fu_result,
   input logic [REG_AW-1:0]        s1_idx,
   input logic                     s1_vld,
   input logic [DATA_W-1:0]        s1_rf,
   input logic [REG_AW-1:0]        s2_idx,
   input logic                     s2_vld,
   input logic [DATA_W-1:0]        s2_rf,
   input logic [DATA_W-1:0]        opnd1,
   input logic                     opnd1_fwd,
   input logic [DATA_W-1:0]        opnd2,
   input logic                     opnd2_fwd
);

   logic hit1, hit2, val1_ok, val2_ok, known;

   always_comb begin
      hit1    = 1'b0;
      hit2    = 1'b0;
      val1_ok = 1'b0;
      val2_ok = 1'b0;
      for (int i = 0; i < NUM_FU; i++) begin
         if (fu_vld[i] && fu_wr[i] && fu_dest[i*REG_AW +: REG_AW] == s1_idx) begin
            hit1 = 1'b1;
            if (opnd1 == fu_result[i*DATA_W +: DATA_W]) val1_ok = 1'b1;
         end
         if (fu_vld[i] && fu_wr[i] && fu_dest[i*REG_AW +: REG_AW] == s2_idx) begin
            hit2 = 1'b1;
            if (opnd2 == fu_result[i*DATA_W +: DATA_W]) val2_ok = 1'b1;
         end
      end
      hit1  = hit1 & s1_vld;
      hit2  = hit2 & s2_vld;
      known = !$isunknown({fu_vld, fu_wr, fu_dest, fu_result, s1_idx, s1_vld,
                           s1_rf, s2_idx, s2_vld, s2_rf, opnd1, opnd1_fwd,
                           opnd2, opnd2_fwd});
   end

   always_comb begin
      if (known) begin
         // R8
         one_writer_chk: assert ($onehot0(fu_vld & fu_wr));
         // R1
         src1_flag_chk: assert (opnd1_fwd == hit1);
         // R2
         src2_flag_chk: assert (opnd2_fwd == hit2);
         // R5
         src1_value_chk: assert (!opnd1_fwd || val1_ok);
         // R5
         src2_value_chk: assert (!opnd2_fwd || val2_ok);
         // R4
         src1_pass_chk: assert (opnd1_fwd || opnd1 == s1_rf);
         // R4
         src2_pass_chk: assert (opnd2_fwd || opnd2 == s2_rf);
      end
   end

endmodule

bind fsel_forward_select fsel_chk #(
   .NUM_FU (NUM_FU),
   .REG_AW (REG_AW),
   .DATA_W (DATA_W)
) i_fsel_chk (
   .fu_vld    (fu_vld),
   .fu_wr     (fu_wr),
   .fu_dest   (fu_dest),
   .fu_result (fu_result),
   .s1_idx    (s1_idx),
   .s1_vld    (s1_vld),
   .s1_rf     (s1_rf),
   .s2_idx    (s2_idx),
   .s2_vld    (s2_vld),
   .s2_rf     (s2_rf),
   .opnd1     (opnd1),
   .opnd1_fwd (opnd1_fwd),
   .opnd2     (opnd2),
   .opnd2_fwd (opnd2_fwd)
);

// File: tb/test_fsel_forward_select.sv
module test_fsel_forward_select;

   localparam int NUM_FU = 3;
   localparam int REG_AW = 2;
   localparam int DATA_W = 8;
   localparam int NREG   = 1 << REG_AW;

   logic                     clk = 1'b0;
   logic [NUM_FU-1:0]        fu_vld;
   logic [NUM_FU-1:0]        fu_wr;
   logic [NUM_FU*REG_AW-1:0] fu_dest;
   logic [NUM_FU*DATA_W-1:0] fu_result;
   logic [REG_AW-1:0]        s1_idx, s2_idx;
   logic                     s1_vld, s2_vld;
   logic [DATA_W-1:0]        s1_rf, s2_rf;
   logic [DATA_W-1:0]        opnd1, opnd2;
   logic                     opnd1_fwd, opnd2_fwd;

   int checks = 0;
   int errors = 0;
   bit done   = 1'b0;

   always #5 clk = ~clk;

   fsel_forward_select #(
      .NUM_FU (NUM_FU),
      .REG_AW (REG_AW),
      .DATA_W (DATA_W)
   ) i_fsel_forward_select (
      .fu_vld    (fu_vld),
      .fu_wr     (fu_wr),
      .fu_dest   (fu_dest),
      .fu_result (fu_result),
      .s1_idx    (s1_idx),
      .s1_vld    (s1_vld),
      .s1_rf     (s1_rf),
      .s2_idx    (s2_idx),
      .s2_vld    (s2_vld),
      .s2_rf     (s2_rf),
      .opnd1     (opnd1),
      .opnd1_fwd (opnd1_fwd),
      .opnd2     (opnd2),
      .opnd2_fwd (opnd2_fwd)
   );

   task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s: got %0h expected %0h", tag, got, exp);
      end
   endtask

   function automatic logic [DATA_W-1:0] unit_res(input int u, input int k);
      return DATA_W'(8'h10 * (u + 1) + (k % 16));
   endfunction

   initial begin
      // idle: nothing completes, operands come straight from the register file
      fu_vld = '0; fu_wr = '0; fu_dest = '0; fu_result = '0;
      s1_idx = '0; s2_idx = '0; s1_vld = 1'b1; s2_vld = 1'b1;
      s1_rf = 8'h5A; s2_rf = 8'hC3;
      @(negedge clk);
      check("R4 idle opnd1", 32'(opnd1), 32'h5A);
      check("R4 idle flag1", 32'(opnd1_fwd), 0);
      check("R4 idle opnd2", 32'(opnd2), 32'hC3);
      check("R4 idle flag2", 32'(opnd2_fwd), 0);

      for (int sel = 0; sel <= NUM_FU; sel++)
      for (int wr = 0; wr < 2; wr++)
      for (int st = 0; st < 2; st++)
      for (int d = 0; d < NREG; d++)
      for (int a = 0; a < NREG; a++)
      for (int b = 0; b < NREG; b++)
      for (int v = 0; v < 4; v++) begin
         int  wu, su, k;
         bit  has_w, exp1, exp2, st_on;
         logic [DATA_W-1:0] e1, e2;
         string t1, t2;
         k     = sel * 7 + d * 3 + a + b + v;
         wu    = sel - 1;
         has_w = (sel > 0) && (wr == 1);
         su    = (sel > 0) ? (wu + 1) % NUM_FU : 0;
         st_on = (st == 1);
         @(posedge clk);
         fu_vld = '0; fu_wr = '0;
         for (int u = 0; u < NUM_FU; u++) begin
            fu_dest[u*REG_AW +: REG_AW]   = REG_AW'(d);
            fu_result[u*DATA_W +: DATA_W] = unit_res(u, k);
         end
         if (sel > 0) begin
            fu_vld[wu] = 1'b1;
            fu_wr[wu]  = (wr == 1);
         end
         if (st_on) begin
            fu_vld[su] = 1'b1;
            fu_wr[su]  = 1'b0;
         end
         s1_idx = REG_AW'(a); s2_idx = REG_AW'(b);
         s1_vld = v[0];       s2_vld = v[1];
         s1_rf  = DATA_W'(8'hA0 + a); s2_rf = DATA_W'(8'hB0 + b);

         exp1 = has_w && v[0] && (a == d);
         exp2 = has_w && v[1] && (b == d);
         e1   = exp1 ? unit_res(wu, k) : DATA_W'(8'hA0 + a);
         e2   = exp2 ? unit_res(wu, k) : DATA_W'(8'hB0 + b);

         if (exp1)                           t1 = st_on ? "R1 R5 R6 opnd1" : "R1 R5 opnd1";
         else if (has_w && !v[0] && a == d)  t1 = "R7 opnd1";
         else if (!has_w && a == d)          t1 = "R6 opnd1";
         else                                t1 = "R4 opnd1";
         if (exp2)                           t2 = st_on ? "R2 R5 R6 opnd2" : "R2 R5 opnd2";
         else if (has_w && !v[1] && b == d)  t2 = "R7 opnd2";
         else if (!has_w && b == d)          t2 = "R6 opnd2";
         else                                t2 = "R4 opnd2";

         @(negedge clk);
         check(t1, 32'(opnd1), 32'(e1));
         check({t1, " flag"}, 32'(opnd1_fwd), 32'(exp1));
         check(t2, 32'(opnd2), 32'(e2));
         check({t2, " flag"}, 32'(opnd2_fwd), 32'(exp2));
         if (exp1 && exp2)
            check("R3 shared result", 32'(opnd1 ^ opnd2), 0);
      end

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog: run did not complete, got timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

endmodule